// File: doc/BRIEF.md
# Power-On Request Controller With Off-Time Guard

This block drives the active-low power-supply-on pin and reports the sleep-state condition to the logic that consumes it. The sleep condition comes from one of two sources, chosen by a select input. One source is the loss of the internal supply-good signal. The other is the external active-low sleep pin or a software sleep bit.

The supply-on pin normally follows the inverse of the external sleep pin. An optional guard can be enabled. With the guard on, the supply cannot be requested again until a minimum number of seconds has passed since the last turn-off. A seconds tick from a slow timebase drives that count. A turn-off always takes effect on the next clock. A turn-on that arrives too early is held pending. It is granted once the guard time has run out, provided the request is still present.

All inputs are synchronous to `clk`. Both outputs are registered and change on the clock edge after the inputs they depend on.

Top module: `pson_ctl`

## Requirements
- R1: With `src_sel`=0, `sleep_state` on the clock after any cycle equals the inverse of `supply_good` in that cycle.
- R2: With `src_sel`=1, `sleep_state` on the clock after any cycle is 1 when `sleep_pin_n` was 0 or `sw_sleep` was 1 in that cycle, and 0 otherwise.
- R3: With `guard_en`=0, `pwr_on_n` on the clock after any cycle equals the inverse of `sleep_pin_n` in that cycle.
- R4: Whenever `sleep_pin_n` is 0 in a cycle, `pwr_on_n` is 1 on the next clock, whatever the guard and the timer state.
- R5: With `guard_en`=1, `pwr_on_n` cannot go from 1 to 0 until GUARD_SECS (default 4) `sec_tick` pulses have been counted since `pwr_on_n` last went from 0 to 1. A tick in the same cycle as the turn-off is not counted. Once the count is reached, a present request drives `pwr_on_n` to 0 on the clock after the one that registered the final tick.
- R6: A turn-on request that is withdrawn before the guard time expires does not drive `pwr_on_n` low.
- R7: In reset, `pwr_on_n` is 1, `sleep_state` is 0 and the off-time count is saturated. The first turn-on after reset is therefore never delayed, even with the guard enabled.
- R8: The off-time count saturates at GUARD_SECS. Extra ticks during a long off period add no delay, and a later request turns the supply on at the next clock.
- R9: While `pwr_on_n` is 0 and `sleep_pin_n` stays 1, `pwr_on_n` stays 0 regardless of ticks or `guard_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, standby domain |
| sec_tick | input | 1 | One-cycle pulse once per second |
| supply_good | input | 1 | Internal supply-good level, 1 = good |
| sleep_pin_n | input | 1 | External sleep pin, active low |
| sw_sleep | input | 1 | Software sleep request bit |
| src_sel | input | 1 | Sleep-condition source: 0 = supply loss, 1 = pin or software bit |
| guard_en | input | 1 | 1 = enforce minimum off-time before turn-on |
| sleep_state | output | 1 | Registered sleep condition |
| pwr_on_n | output | 1 | Supply-on request, active low |

## Verification
The hardest situation to reach is a turn-on request that is withdrawn and reissued at different points of the guard window. This includes a withdrawal just before the final tick and a tick that coincides with the turn-off. Random stimulus rarely lines these up with the tick phase, so the bench covers them with directed sequences that place ticks and request edges on chosen cycles. It then runs several thousand random cycles with sparse ticks and slowly changing pin, guard and source inputs. During those cycles a bench model of the off-time count predicts every output.

// File: rtl/pson_pkg.sv
package pson_pkg;

  typedef enum logic {
    SRC_SUPPLY_LOSS = 1'b0,
    SRC_PIN_OR_SW   = 1'b1
  } sleep_src_e;

  // Sleep condition seen by downstream logic for the chosen source.
  function automatic logic sleep_cond(input sleep_src_e sel, input logic supply_ok,
                                      input logic pin_n, input logic sw_bit);
    logic r;
    if (sel == SRC_PIN_OR_SW) r = (~pin_n) | sw_bit;
    else                      r = ~supply_ok;
    return r;
  endfunction

  // Next level of the active-low supply-on pin.
  function automatic logic pson_next(input logic cur_n, input logic request,
                                     input logic grant_ok);
    logic r;
    if (!request)     r = 1'b1;   // turn-off is immediate
    else if (!cur_n)  r = 1'b0;   // already on, stays on
    else if (grant_ok) r = 1'b0;  // off, allowed to turn on
    else              r = 1'b1;   // off, request pending
    return r;
  endfunction

endpackage

// File: rtl/sleep_src_sel.sv
module sleep_src_sel
  import pson_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic supply_good,
  input  logic sleep_pin_n,
  input  logic sw_sleep,
  input  logic src_sel,
  output logic sleep_state
);

  sleep_src_e src;
  logic       cond_now;

  assign src      = sleep_src_e'(src_sel);
  assign cond_now = sleep_cond(src, supply_good, sleep_pin_n, sw_sleep);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sleep_state <= 1'b0;
    else        sleep_state <= cond_now;
  end

  // R1: supply-loss source
  p_supply_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !src_sel |=> (sleep_state == !$past(supply_good)));

  // R2: pin-or-software source
  p_pin_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel && (!sleep_pin_n || sw_sleep)) |=> sleep_state);

  p_pin_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel && sleep_pin_n && !sw_sleep) |=> !sleep_state);

endmodule

// File: rtl/offtime_timer.sv
module offtime_timer #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_tick,
  input  logic restart,
  output logic expired
);

  localparam int CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  function automatic logic [CW-1:0] cnt_next(input logic [CW-1:0] c, input logic tk,
                                             input logic rs);
    logic [CW-1:0] r;
    if (rs)                 r = '0;
    else if (tk && c < LIM) r = c + 1'b1;
    else                    r = c;
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= LIM;   // saturated: first turn-on is never held
    else        cnt <= cnt_next(cnt, sec_tick, restart);
  end

  assign expired = (cnt >= LIM);

  // R8: count never passes its limit
  p_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIM);

  // R8: once saturated it stays expired until a restart
  p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !restart) |=> expired);

  // R5: a restart opens a fresh guard window
  p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));

endmodule

// File: rtl/pson_ctl.sv
module pson_ctl
  import pson_pkg::*;
#(
  parameter int GUARD_SECS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_tick,
  input  logic supply_good,
  input  logic sleep_pin_n,
  input  logic sw_sleep,
  input  logic src_sel,
  input  logic guard_en,
  output logic sleep_state,
  output logic pwr_on_n
);

  logic turn_off_evt;   // supply going from on to off this cycle
  logic guard_expired;  // off-time window has run out
  logic grant_ok;       // a pending request may be honoured
  logic pson_d;

  sleep_src_sel u_src (
    .clk         (clk),
    .rst_n       (rst_n),
    .supply_good (supply_good),
    .sleep_pin_n (sleep_pin_n),
    .sw_sleep    (sw_sleep),
    .src_sel     (src_sel),
    .sleep_state (sleep_state)
  );

  assign turn_off_evt = !pwr_on_n && !sleep_pin_n;

  offtime_timer #(.LIMIT(GUARD_SECS)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .sec_tick (sec_tick),
    .restart  (turn_off_evt),
    .expired  (guard_expired)
  );

  assign grant_ok = !guard_en || guard_expired;
  assign pson_d   = pson_next(pwr_on_n, sleep_pin_n, grant_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwr_on_n <= 1'b1;
    else        pwr_on_n <= pson_d;
  end

  // R4: turn-off is immediate
  p_off_now_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_pin_n |=> pwr_on_n);

  // R3: plain inversion when the guard is off
  p_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !guard_en |=> (pwr_on_n == $past(!sleep_pin_n)));

  // R5: guard holds the supply off inside the window
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (guard_en && pwr_on_n && !guard_expired) |=> pwr_on_n);

  // R9: an on supply with a standing request stays on
  p_stay_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_on_n && sleep_pin_n) |=> !pwr_on_n);

endmodule

// File: tb/sim_pson_ctl.sv
`timescale 1ns/1ps
module sim_pson_ctl;

  localparam int GS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_tick = 1'b0, supply_good = 1'b1, sleep_pin_n = 1'b0;
  logic sw_sleep = 1'b0, src_sel = 1'b0, guard_en = 1'b0;
  logic sleep_state, pwr_on_n;

  int total = 0, bad = 0;
  bit done = 1'b0;

  // bench model
  logic m_pson, m_sleep;
  int   m_cnt;

  always #5 clk = ~clk;

  pson_ctl #(.GUARD_SECS(GS)) u0 (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .supply_good(supply_good),
    .sleep_pin_n(sleep_pin_n), .sw_sleep(sw_sleep), .src_sel(src_sel),
    .guard_en(guard_en), .sleep_state(sleep_state), .pwr_on_n(pwr_on_n)
  );

  function automatic logic exp_sleep(logic sel, logic sg, logic pn, logic sw);
    return sel ? (!pn || sw) : !sg;
  endfunction

  function automatic logic exp_pson(logic cur, logic req, logic grd, int cnt);
    if (!req) return 1'b1;
    if (!cur) return 1'b0;
    return (grd && cnt < GS) ? 1'b1 : 1'b0;
  endfunction

  function automatic int exp_cnt(logic cur, logic req, logic tk, int cnt);
    if (!cur && !req) return 0;
    if (tk && cnt < GS) return cnt + 1;
    return cnt;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: model follows inputs, then outputs compared at the falling edge
  task automatic cyc();
    logic np, ns;
    int   nc;
    np = exp_pson(m_pson, sleep_pin_n, guard_en, m_cnt);
    ns = exp_sleep(src_sel, supply_good, sleep_pin_n, sw_sleep);
    nc = exp_cnt(m_pson, sleep_pin_n, sec_tick, m_cnt);
    @(negedge clk);
    m_pson = np; m_sleep = ns; m_cnt = nc;
    chk(src_sel ? "R2" : "R1", sleep_state, m_sleep);
    chk(!sleep_pin_n ? "R4" : (guard_en ? "R5" : "R3"), pwr_on_n, m_pson);
  endtask

  task automatic ticks(int n, int gap);
    for (int i = 0; i < n; i++) begin
      sec_tick = 1'b1; cyc(); sec_tick = 1'b0;
      for (int j = 0; j < gap; j++) cyc();
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_pson = 1'b1; m_sleep = 1'b0; m_cnt = GS;
    sleep_pin_n = 1'b1; guard_en = 1'b1; src_sel = 1'b1;
    repeat (3) @(negedge clk);
    // R7: reset values
    chk("R7", pwr_on_n, 1'b1);
    chk("R7", sleep_state, 1'b0);
    rst_n = 1'b1;
    // R7: first turn-on with guard set is not delayed
    cyc();
    chk("R7", pwr_on_n, 1'b0);

    // R4 + R5: turn off, then request immediately with a tick on the off cycle
    sleep_pin_n = 1'b0; sec_tick = 1'b1; cyc(); sec_tick = 1'b0;
    chk("R4", pwr_on_n, 1'b1);
    sleep_pin_n = 1'b1;
    ticks(GS - 1, 3);
    chk("R5", pwr_on_n, 1'b1);
    sec_tick = 1'b1; cyc(); sec_tick = 1'b0;
    chk("R5", pwr_on_n, 1'b1);
    cyc();
    chk("R5", pwr_on_n, 1'b0);
    // R9: on state survives ticks and guard changes
    guard_en = 1'b0; ticks(2, 1); guard_en = 1'b1; ticks(2, 1);
    chk("R9", pwr_on_n, 1'b0);

    // R6: request withdrawn before expiry never turns the supply on
    sleep_pin_n = 1'b0; cyc();
    sleep_pin_n = 1'b1; ticks(2, 2);
    sleep_pin_n = 1'b0; ticks(GS, 2);
    repeat (3) cyc();
    chk("R6", pwr_on_n, 1'b1);
    // R8: saturated count, extra ticks, request granted next clock
    ticks(6, 1);
    sleep_pin_n = 1'b1; cyc();
    chk("R8", pwr_on_n, 1'b0);

    // R3: guard off, turn-on straight after turn-off
    guard_en = 1'b0;
    sleep_pin_n = 1'b0; cyc(); sleep_pin_n = 1'b1; cyc();
    chk("R3", pwr_on_n, 1'b0);

    // R1 / R2 source selection corners
    src_sel = 1'b0; supply_good = 1'b0; cyc(); chk("R1", sleep_state, 1'b1);
    supply_good = 1'b1; sw_sleep = 1'b1; cyc(); chk("R1", sleep_state, 1'b0);
    src_sel = 1'b1; cyc(); chk("R2", sleep_state, 1'b1);
    sw_sleep = 1'b0; cyc(); chk("R2", sleep_state, 1'b0);

    // random phase
    for (int k = 0; k < 6000; k++) begin
      sec_tick = (($urandom % 8) == 0);
      if (($urandom % 6) == 0)   sleep_pin_n = ~sleep_pin_n;
      if (($urandom % 200) == 0) guard_en    = ~guard_en;
      if (($urandom % 50) == 0)  src_sel     = ~src_sel;
      if (($urandom % 5) == 0)   supply_good = ~supply_good;
      if (($urandom % 7) == 0)   sw_sleep    = ~sw_sleep;
      cyc();
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule